// File: doc/BRIEF.md
# DDR3 Mode Register Init Sequencer

This block produces the command words that bring DDR3 devices out of reset into a usable mode. A controller's special-command register takes them one at a time over a valid/ready handshake. A one-cycle start pulse captures the timing and termination settings. The block then raises a configuration request. For every populated rank it loads the four mode registers and then asks for a long ZQ calibration. At the end it writes an all-zero word, which drops the request.

Every word shares one layout. A 16-bit payload sits in bits 31:16 and a request flag in bit 15. The command code is in bits 6:4, the rank select in bit 3 and the mode-register bank in bits 2:0. The block stays busy for the whole run and marks the end with a single done pulse. It sits between a boot-time configuration source and the memory controller's command port. It does not time commands on the DRAM bus.

Top module: `ddr3_mr_init_seq`

## Requirements
- R1: While reset is held and after it is released, busy_o, cmd_valid_o and done_o are low and cmd_o is zero until a start is accepted.
- R2: The first word after an accepted start is 0x0000_8000: the request flag only, with code, rank and bank all zero.
- R3: Each rank is issued MR2, MR3, MR1, MR0 and then ZQ, in that order. All five words for rank 0 come before any word for rank 1. Bit 3 of each of these words carries the rank index.
- R4: Mode-register loads use code 3 in bits 6:4, with the bank field set to the register number (MR0=0, MR1=1, MR2=2, MR3=3). The ZQ word uses code 4, bank 0 and payload bit 10. All of these words have bit 15 set.
- R5: The MR2 payload holds rtt_wr_i in bits 10:9, srt_i in bit 7 and (cwl_i − 3) modulo 4 in bits 4:3. All other payload bits are zero.
- R6: The MR3 payload is zero. The MR1 payload has bit 2 equal to rtt_nom_i[0] and bit 6 equal to rtt_nom_i[1]. All other bits are zero.
- R7: The MR0 payload holds (cl_i − 1) modulo 16 in bits 7:4, a 1 in bit 8, (wr_i − 3) modulo 8 in bits 11:9 and fast_pd_exit_i in bit 12. All other bits are zero.
- R8: After the last rank the block issues a word of all zeros. A cs_count_i of 2 gives two ranks; any other value gives one.
- R9: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high and cmd_o does not change. Each accepted handshake moves the block on by exactly one word.
- R10: busy_o goes high the cycle after an accepted start. It stays high until the clock edge that accepts the all-zero word. In the following cycle done_o is high for exactly one cycle while busy_o is low.
- R11: A start while busy is ignored. The settings are captured when start is accepted, so later changes to the setting inputs do not affect the words of the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a sequence when idle |
| cwl_i | input | 4 | CAS write latency in cycles |
| cl_i | input | 4 | CAS latency in cycles |
| wr_i | input | 4 | Write recovery in cycles |
| rtt_wr_i | input | 2 | Dynamic write termination code |
| rtt_nom_i | input | 2 | Nominal termination selector bits |
| srt_i | input | 1 | Self-refresh temperature range |
| fast_pd_exit_i | input | 1 | Fast exit from precharge power-down |
| cs_count_i | input | 2 | Populated rank count (2 = two ranks) |
| cmd_ready_i | input | 1 | Command port accepts the current word |
| cmd_o | output | 32 | Command word |
| cmd_valid_o | output | 1 | Command word valid |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the final word |

## Verification
The bench holds ready low at random points. A design that advanced on valid alone, or changed the word during a stall, would skip or corrupt words, and the scoreboard catches this. It runs both one-rank and two-rank sequences, including a cs_count_i of 0, which must act as one rank. A wrong rank limit shows up as missing or extra words. Settings at their edges (CWL of 3, both termination selector bits set, large CL and WR) expose bad subtraction or field masking. A second start arrives during a run together with changed settings. A block that restarted or read its inputs live would emit words the queue does not expect.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;
  localparam int LAT_W     = 4;
  localparam int NUM_RANKS = 2;
  localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;
  localparam int WORD_W    = 32;
  localparam int PL_W      = 16;

  localparam int PL_LSB    = 16;
  localparam int FLAG_BIT  = 15;
  localparam int CODE_LSB  = 4;
  localparam int CODE_W    = 3;
  localparam int CS_BIT    = 3;
  localparam int BANK_W    = 3;

  localparam logic [CODE_W-1:0] CODE_LMR = 3'd3;
  localparam logic [CODE_W-1:0] CODE_ZQ  = 3'd4;

  typedef enum logic [2:0] {
    ST_REQ, ST_MR2, ST_MR3, ST_MR1, ST_MR0, ST_ZQ, ST_REL
  } step_e;

  typedef struct packed {
    logic [LAT_W-1:0] cwl;
    logic [LAT_W-1:0] cl;
    logic [LAT_W-1:0] wr;
    logic [1:0]       rtt_wr;
    logic [1:0]       rtt_nom;
    logic             srt;
    logic             fpd;
    logic             two_ranks;
  } cfg_t;

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [PL_W-1:0]   pl,
    input logic              flag,
    input logic [CODE_W-1:0] code,
    input logic              cs,
    input logic [BANK_W-1:0] bank
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[PL_LSB +: PL_W]     = pl;
    w[FLAG_BIT]           = flag;
    w[CODE_LSB +: CODE_W] = code;
    w[CS_BIT]             = cs;
    w[0 +: BANK_W]        = bank;
    return w;
  endfunction
endpackage

// File: rtl/ddr3_init_cfg_latch.sv
module ddr3_init_cfg_latch
  import ddr3_init_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] cwl_i,
  input  logic [LAT_W-1:0] cl_i,
  input  logic [LAT_W-1:0] wr_i,
  input  logic [1:0]       rtt_wr_i,
  input  logic [1:0]       rtt_nom_i,
  input  logic             srt_i,
  input  logic             fpd_i,
  input  logic [1:0]       cs_count_i,
  output cfg_t             cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (load_i) begin
      cfg_o.cwl       <= cwl_i;
      cfg_o.cl        <= cl_i;
      cfg_o.wr        <= wr_i;
      cfg_o.rtt_wr    <= rtt_wr_i;
      cfg_o.rtt_nom   <= rtt_nom_i;
      cfg_o.srt       <= srt_i;
      cfg_o.fpd       <= fpd_i;
      cfg_o.two_ranks <= (cs_count_i == 2'd2);
    end
  end
endmodule

// File: rtl/ddr3_init_fsm.sv
module ddr3_init_fsm
  import ddr3_init_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ready_i,
  input  logic              two_ranks_i,
  output logic              load_o,
  output logic              active_o,
  output step_e             step_o,
  output logic [RANK_W-1:0] rank_o,
  output logic              done_o
);
  logic              last_rank;
  logic [RANK_W-1:0] rank_max;

  assign rank_max  = two_ranks_i ? RANK_W'(NUM_RANKS - 1) : '0;
  assign last_rank = (rank_o == rank_max);
  assign load_o    = start_i && !active_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      step_o   <= ST_REQ;
      rank_o   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active_o) begin
        if (start_i) begin
          active_o <= 1'b1;
          step_o   <= ST_REQ;
          rank_o   <= '0;
        end
      end else if (ready_i) begin
        unique case (step_o)
          ST_REQ: step_o <= ST_MR2;
          ST_MR2: step_o <= ST_MR3;
          ST_MR3: step_o <= ST_MR1;
          ST_MR1: step_o <= ST_MR0;
          ST_MR0: step_o <= ST_ZQ;
          ST_ZQ: begin
            if (last_rank) begin
              step_o <= ST_REL;
            end else begin
              rank_o <= rank_o + 1'b1;
              step_o <= ST_MR2;
            end
          end
          ST_REL: begin
            active_o <= 1'b0;
            done_o   <= 1'b1;
            step_o   <= ST_REQ;
            rank_o   <= '0;
          end
          default: step_o <= ST_REQ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ddr3_init_word_gen.sv
module ddr3_init_word_gen
  import ddr3_init_pkg::*;
(
  input  logic              active_i,
  input  step_e             step_i,
  input  logic [RANK_W-1:0] rank_i,
  input  cfg_t              cfg_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int MR2_RTTWR_LSB = 9;
  localparam int MR2_SRT_BIT   = 7;
  localparam int MR2_CWL_LSB   = 3;
  localparam int MR1_NOM0_BIT  = 2;
  localparam int MR1_NOM1_BIT  = 6;
  localparam int MR0_CL_LSB    = 4;
  localparam int MR0_DLL_BIT   = 8;
  localparam int MR0_WR_LSB    = 9;
  localparam int MR0_FPD_BIT   = 12;
  localparam int ZQ_LONG_BIT   = 10;

  logic [LAT_W-1:0]  cwl_m3, cl_m1, wr_m3;
  logic [PL_W-1:0]   pl;
  logic              flag, cs;
  logic [CODE_W-1:0] code;
  logic [BANK_W-1:0] bank;

  assign cwl_m3 = cfg_i.cwl - LAT_W'(3);
  assign cl_m1  = cfg_i.cl  - LAT_W'(1);
  assign wr_m3  = cfg_i.wr  - LAT_W'(3);

  always_comb begin
    pl   = '0;
    flag = 1'b1;
    code = CODE_LMR;
    bank = '0;
    cs   = rank_i[0];
    unique case (step_i)
      ST_REQ: begin
        code = '0;
        cs   = 1'b0;
      end
      ST_MR2: begin
        pl[MR2_RTTWR_LSB +: 2] = cfg_i.rtt_wr;
        pl[MR2_SRT_BIT]        = cfg_i.srt;
        pl[MR2_CWL_LSB +: 2]   = cwl_m3[1:0];
        bank                   = 3'd2;
      end
      ST_MR3: bank = 3'd3;
      ST_MR1: begin
        pl[MR1_NOM0_BIT] = cfg_i.rtt_nom[0];
        pl[MR1_NOM1_BIT] = cfg_i.rtt_nom[1];
        bank             = 3'd1;
      end
      ST_MR0: begin
        pl[MR0_CL_LSB +: 4] = cl_m1[3:0];
        pl[MR0_DLL_BIT]     = 1'b1;
        pl[MR0_WR_LSB +: 3] = wr_m3[2:0];
        pl[MR0_FPD_BIT]     = cfg_i.fpd;
      end
      ST_ZQ: begin
        pl[ZQ_LONG_BIT] = 1'b1;
        code            = CODE_ZQ;
      end
      ST_REL: begin
        flag = 1'b0;
        code = '0;
        cs   = 1'b0;
      end
      default: begin
        flag = 1'b0;
        code = '0;
        cs   = 1'b0;
      end
    endcase
  end

  assign word_o = active_i ? pack_word(pl, flag, code, cs, bank) : '0;
endmodule

// File: rtl/ddr3_mr_init_seq.sv
module ddr3_mr_init_seq
  import ddr3_init_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LAT_W-1:0]  cwl_i,
  input  logic [LAT_W-1:0]  cl_i,
  input  logic [LAT_W-1:0]  wr_i,
  input  logic [1:0]        rtt_wr_i,
  input  logic [1:0]        rtt_nom_i,
  input  logic              srt_i,
  input  logic              fast_pd_exit_i,
  input  logic [1:0]        cs_count_i,
  input  logic              cmd_ready_i,
  output logic [WORD_W-1:0] cmd_o,
  output logic              cmd_valid_o,
  output logic              busy_o,
  output logic              done_o
);
  cfg_t              cfg;
  logic              load, active;
  step_e             step;
  logic [RANK_W-1:0] rank;

  ddr3_init_cfg_latch u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .cwl_i      (cwl_i),
    .cl_i       (cl_i),
    .wr_i       (wr_i),
    .rtt_wr_i   (rtt_wr_i),
    .rtt_nom_i  (rtt_nom_i),
    .srt_i      (srt_i),
    .fpd_i      (fast_pd_exit_i),
    .cs_count_i (cs_count_i),
    .cfg_o      (cfg)
  );

  ddr3_init_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ready_i     (cmd_ready_i),
    .two_ranks_i (cfg.two_ranks),
    .load_o      (load),
    .active_o    (active),
    .step_o      (step),
    .rank_o      (rank),
    .done_o      (done_o)
  );

  ddr3_init_word_gen u_word (
    .active_i (active),
    .step_i   (step),
    .rank_i   (rank),
    .cfg_i    (cfg),
    .word_o   (cmd_o)
  );

  assign cmd_valid_o = active;
  assign busy_o      = active;
endmodule

// File: rtl/ddr3_mr_init_seq_chk.sv
module ddr3_mr_init_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        cmd_ready_i,
  input logic [31:0] cmd_o,
  input logic        cmd_valid_o,
  input logic        busy_o,
  input logic        done_o
);
  // R9
  hold_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_o));

  // R8
  release_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i && (cmd_o == 32'h0) |=> !cmd_valid_o && done_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R2
  req_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> cmd_o == 32'h0000_8000);

  // R4
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && (cmd_o != 32'h0) |-> cmd_o[15]);

  // R11
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_o));
endmodule

bind ddr3_mr_init_seq ddr3_mr_init_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cmd_ready_i (cmd_ready_i),
  .cmd_o       (cmd_o),
  .cmd_valid_o (cmd_valid_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/ddr3_mr_init_seq_test.sv
module ddr3_mr_init_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  cwl_i = '0, cl_i = '0, wr_i = '0;
  logic [1:0]  rtt_wr_i = '0, rtt_nom_i = '0, cs_count_i = '0;
  logic        srt_i = 1'b0, fast_pd_exit_i = 1'b0;
  logic        cmd_ready_i = 1'b0;
  logic [31:0] cmd_o;
  logic        cmd_valid_o, busy_o, done_o;

  int errors = 0;
  int checks = 0;
  int accepted = 0;
  int dones = 0;
  int cycles = 0;
  bit rdy_rand = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  bit held = 1'b0;
  logic [31:0] held_word = '0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  ddr3_mr_init_seq uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input logic [15:0] pl, input logic [2:0] code,
                                      input logic cs, input logic [2:0] bank);
    return {pl, 1'b1, 8'h00, code, cs, bank};
  endfunction

  task automatic push(input logic [31:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  // monitor: pick ready for the coming edge, then score what that edge accepts
  always @(negedge clk_i) begin
    cycles++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready_i = rdy_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
    if (held) begin
      check(cmd_valid_o && cmd_o == held_word, "R9 hold", cmd_o, held_word);
      held = 1'b0;
    end
    if (cmd_valid_o && !cmd_ready_i) begin
      held = 1'b1;
      held_word = cmd_o;
    end
    if (cmd_valid_o && cmd_ready_i) begin
      accepted++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 extra word", cmd_o, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cmd_o == e, t, cmd_o, e);
      end
    end
    if (done_o) begin
      dones++;
      check(!busy_o && exp_q.size() == 0, "R10 done with idle and empty queue",
            {31'h0, busy_o}, 32'h0);
    end
  end

  initial begin
    while (cycles < WDOG_LIMIT) @(posedge clk_i);
    check(1'b0, "watchdog", 32'(cycles), 32'(WDOG_LIMIT));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic run_seq(input logic [3:0] cwl, input logic [3:0] cl, input logic [3:0] wr,
                         input logic [1:0] rw, input logic [1:0] rn, input logic srt,
                         input logic fpd, input logic [1:0] ncs, input bit disturb);
    int nr;
    int d0, a0, nexp;
    nr = (ncs == 2'd2) ? 2 : 1;
    push(32'h0000_8000, "R2 request word");
    for (int r = 0; r < nr; r++) begin
      push(mkw({5'b0, rw, 1'b0, srt, 2'b0, 2'(cwl - 4'd3), 3'b0}, 3'd3, r[0], 3'd2), "R3 R5 MR2");
      push(mkw(16'h0, 3'd3, r[0], 3'd3), "R3 R6 MR3");
      push(mkw({9'b0, rn[1], 3'b0, rn[0], 2'b0}, 3'd3, r[0], 3'd1), "R3 R6 MR1");
      push(mkw({3'b0, fpd, 3'(wr - 4'd3), 1'b1, 4'(cl - 4'd1), 4'b0}, 3'd3, r[0], 3'd0), "R3 R7 MR0");
      push(mkw(16'h0400, 3'd4, r[0], 3'd0), "R3 R4 ZQ");
    end
    push(32'h0, "R8 release word");
    nexp = exp_q.size();
    d0 = dones;
    a0 = accepted;
    @(negedge clk_i);
    cwl_i = cwl; cl_i = cl; wr_i = wr; rtt_wr_i = rw; rtt_nom_i = rn;
    srt_i = srt; fast_pd_exit_i = fpd; cs_count_i = ncs; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R10 busy after start", {31'h0, busy_o}, 32'h1);
    if (disturb) begin
      repeat (3) @(negedge clk_i);
      cwl_i = ~cwl; cl_i = ~cl; wr_i = ~wr; rtt_wr_i = ~rw; rtt_nom_i = ~rn;
      srt_i = ~srt; fast_pd_exit_i = ~fpd; cs_count_i = (ncs == 2'd2) ? 2'd1 : 2'd2;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (dones == d0) @(negedge clk_i);
    check(accepted - a0 == nexp, "R11 R8 word count", 32'(accepted - a0), 32'(nexp));
    @(negedge clk_i);
    check(!done_o && !busy_o && !cmd_valid_o, "R10 done is one cycle",
          {29'h0, done_o, busy_o, cmd_valid_o}, 32'h0);
    repeat (3) @(negedge clk_i);
    check(dones == d0 + 1 && !cmd_valid_o, "R10 stays idle", 32'(dones - d0), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!busy_o && !cmd_valid_o && !done_o && cmd_o == 0, "R1 in reset",
          cmd_o, 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !cmd_valid_o && !done_o && cmd_o == 0, "R1 after reset",
          cmd_o, 32'h0);

    rdy_rand = 1'b0;
    run_seq(4'd5, 4'd6, 4'd6, 2'd1, 2'd1, 1'b0, 1'b1, 2'd1, 1'b0);
    rdy_rand = 1'b1;
    run_seq(4'd6, 4'd8, 4'd8, 2'd2, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0);
    run_seq(4'd7, 4'd11, 4'd10, 2'd3, 2'd3, 1'b1, 1'b1, 2'd2, 1'b1);
    run_seq(4'd3, 4'd5, 4'd5, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1);
    rdy_rand = 1'b0;
    run_seq(4'd8, 4'd14, 4'd12, 2'd1, 2'd2, 1'b0, 1'b1, 2'd3, 1'b0);

    check(exp_q.size() == 0, "R3 queue drained", 32'(exp_q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule